// File: doc/BRIEF.md
# BCD Calendar Clock with Hundredths

This block is a calendar counter that advances once for every pulse of a 100 Hz tick enable. It keeps the time and date in eight packed-BCD byte registers: hundredths, seconds, minutes, hours, day of week, date, month and year. All eight registers are visible together on a 64-bit read port. A 64-bit parallel load port writes all eight at once.

The mode bits live inside the data. Hours bit 7 selects 12-hour counting, and in that mode hours bit 5 carries the afternoon flag. In 24-hour mode the same bit 5 is the upper tens digit of the hour. Day-of-week bit 5 is a run/stop control: while it is 1 the counters hold still. Month lengths and leap-year Februaries are applied automatically, so software only sets the time and then reads it.

Byte k of the 64-bit word sits at bits [8k+7:8k]. The bytes are, from k = 0 to 7: hundredths, seconds, minutes, hours, day of week, date, month, year.

Top module: `bcd_calendar_clock`

## Requirements
- R1: Each tick advances byte 0 by one hundredth in BCD (tenths in bits 7:4, hundredths in bits 3:0). 99 wraps to 00 and carries into seconds. Without a tick and without a load, the word holds.
- R2: Seconds (byte 1) and minutes (byte 2) count 00 to 59 in BCD, each with bit 7 held at 0. A wrap from 59 to 00 carries into the next byte.
- R3: With hours bit 7 = 0 (24-hour mode), hours count 00 to 23, with bits 5:4 as the tens digit. A carry at 23 gives 00 and advances the date.
- R4: With hours bit 7 = 1 (12-hour mode), bit 5 is the afternoon flag (1 = PM) and bit 4 is the tens digit. 11 goes to 12 and toggles the flag, and 12 goes to 01 without toggling. The date advances only on the step from 11 PM to 12 AM.
- R5: Day of week (byte 4, bits 2:0) counts 1 to 7 and goes from 7 to 1, stepping once per date advance.
- R6: The date (byte 5) goes back to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February. The month then advances.
- R7: In February the date goes back to 01 after day 29 when the year value is divisible by 4 (00 included), and after day 28 otherwise.
- R8: Month (byte 6) goes from 12 to 01 and advances the year (byte 7). Year 99 goes to 00.
- R9: While byte 4 bit 5 is 1, ticks leave the whole word unchanged. While it is 0, counting proceeds.
- R10: A load writes the load word (with zero bits cleared) in the next cycle. A tick in the same cycle is discarded.
- R11: Hard-zero bits always read 0, whatever value is loaded into them: byte 1 bit 7, byte 2 bit 7, byte 3 bit 6, byte 4 bits 7, 6, 4 and 3, byte 5 bits 7:6, and byte 6 bits 7:5.
- R12: After reset the word reads 64'h0001_0101_0000_0000: 00:00:00.00 in 24-hour mode, running, day 1, date 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 100 Hz step enable, one cycle per hundredth |
| load_i | input | 1 | Parallel write strobe for all eight bytes |
| load_data_i | input | 64 | Word written on a load |
| time_o | output | 64 | Current contents of the eight registers |

## Verification
The bench builds the block with its default reset word and drives ticks on chosen cycles rather than at a real 100 Hz rate. This means every tick is a single clock. Loading presets a few hundredths before a boundary brings every rollover within a handful of cycles: the end of an hour, the morning and evening 12-hour turnovers, short months, leap and common Februaries, and the turn of the century. The run/stop bit, loads that collide with ticks, and writes of ones into hard-zero bits are covered the same way.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NREG   = 8;
  localparam int BYTE_W = 8;
  localparam int WORD_W = NREG * BYTE_W;

  localparam int R_HUND = 0;
  localparam int R_SEC  = 1;
  localparam int R_MIN  = 2;
  localparam int R_HOUR = 3;
  localparam int R_DOW  = 4;
  localparam int R_DATE = 5;
  localparam int R_MON  = 6;
  localparam int R_YEAR = 7;

  localparam int RUNSTOP_BIT = 5;  // within the day-of-week byte
  localparam int MODE12_BIT  = 7;  // within the hours byte
  localparam int PM_BIT      = 5;  // within the hours byte

  // Bits that can ever hold a one, per register
  function automatic logic [BYTE_W-1:0] keep_mask(input int k);
    case (k)
      R_SEC, R_MIN: return 8'h7F;
      R_HOUR:       return 8'hBF;
      R_DOW:        return 8'h27;
      R_DATE:       return 8'h3F;
      R_MON:        return 8'h1F;
      default:      return 8'hFF;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] word_keep();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < NREG; k++) m[k*BYTE_W +: BYTE_W] = keep_mask(k);
    return m;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
    logic [6:0] t;
    logic [6:0] u;
    t = v / 7'd10;
    u = v % 7'd10;
    return {t[3:0], u[3:0]};
  endfunction

  // Step a BCD byte, wrapping to lo once it has reached hi
  function automatic logic [7:0] bcd_step(input logic [7:0] cur,
                                          input logic [6:0] lo,
                                          input logic [6:0] hi);
    logic [6:0] v;
    v = bcd_to_bin(cur);
    if (v >= hi) return bin_to_bcd(lo);
    return bin_to_bcd(v + 7'd1);
  endfunction

  function automatic logic is_leap(input logic [7:0] year_bcd);
    logic [6:0] v;
    v = bcd_to_bin(year_bcd);
    return (v[1:0] == 2'b00);
  endfunction

  function automatic logic [6:0] month_days(input logic [7:0] mon_bcd,
                                            input logic [7:0] year_bcd);
    case (bcd_to_bin(mon_bcd))
      7'd2:                    return is_leap(year_bcd) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      default:                 return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_time_chain.sv
module cal_time_chain
  import cal_pkg::*;
(
  input  logic       step_i,
  input  logic [7:0] hund_i,
  input  logic [7:0] sec_i,
  input  logic [7:0] min_i,
  input  logic [7:0] hour_i,
  output logic [7:0] hund_o,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       day_roll_o
);
  logic       hund_wrap, sec_wrap, min_wrap;
  logic       mode12, pm;
  logic [6:0] h12, h24;
  logic [7:0] nb;

  assign hund_wrap = step_i    && (bcd_to_bin(hund_i) >= 7'd99);
  assign sec_wrap  = hund_wrap && (bcd_to_bin(sec_i)  >= 7'd59);
  assign min_wrap  = sec_wrap  && (bcd_to_bin(min_i)  >= 7'd59);

  assign hund_o = step_i    ? bcd_step(hund_i, 7'd0, 7'd99) : hund_i;
  assign sec_o  = hund_wrap ? bcd_step(sec_i,  7'd0, 7'd59) : sec_i;
  assign min_o  = sec_wrap  ? bcd_step(min_i,  7'd0, 7'd59) : min_i;

  assign mode12 = hour_i[MODE12_BIT];
  assign pm     = hour_i[PM_BIT];
  assign h12    = bcd_to_bin(hour_i & 8'h1F);
  assign h24    = bcd_to_bin(hour_i & 8'h3F);

  always_comb begin
    hour_o     = hour_i;
    day_roll_o = 1'b0;
    nb         = 8'h00;
    if (min_wrap) begin
      if (mode12) begin
        nb = bin_to_bcd(h12 + 7'd1);
        if (h12 == 7'd11) begin
          hour_o     = {2'b10, ~pm, 5'h12};
          day_roll_o = pm;
        end else if (h12 >= 7'd12) begin
          hour_o = {2'b10, pm, 5'h01};
        end else begin
          hour_o = {2'b10, pm, nb[4:0]};
        end
      end else begin
        nb = bin_to_bcd(h24 + 7'd1);
        if (h24 >= 7'd23) begin
          hour_o     = 8'h00;
          day_roll_o = 1'b1;
        end else begin
          hour_o = {2'b00, nb[5:0]};
        end
      end
    end
  end
endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
  import cal_pkg::*;
(
  input  logic       roll_i,
  input  logic [7:0] dow_i,
  input  logic [7:0] date_i,
  input  logic [7:0] mon_i,
  input  logic [7:0] year_i,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       year_wrap_o
);
  logic [6:0] last_day;
  logic       date_wrap, mon_wrap;
  logic [2:0] dow_next;

  assign last_day  = month_days(mon_i, year_i);
  assign date_wrap = roll_i    && (bcd_to_bin(date_i) >= last_day);
  assign mon_wrap  = date_wrap && (bcd_to_bin(mon_i)  >= 7'd12);
  assign year_wrap_o = mon_wrap && (bcd_to_bin(year_i) >= 7'd99);

  assign dow_next = (dow_i[2:0] >= 3'd7) ? 3'd1 : dow_i[2:0] + 3'd1;
  assign dow_o    = roll_i ? {dow_i[7:3], dow_next} : dow_i;

  assign date_o = roll_i    ? bcd_step(date_i, 7'd1, last_day) : date_i;
  assign mon_o  = date_wrap ? bcd_step(mon_i,  7'd1, 7'd12)    : mon_i;
  assign year_o = mon_wrap  ? bcd_step(year_i, 7'd0, 7'd99)    : year_i;
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
#(
  parameter logic [63:0] RESET_VALUE = 64'h0001_0101_0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        load_i,
  input  logic [63:0] load_data_i,
  output logic [63:0] time_o
);
  logic [WORD_W-1:0] cur_w;
  logic [WORD_W-1:0] nxt_w;
  logic              osc_stop;
  logic              step_en;
  logic              day_roll;
  logic              year_wrap;

  assign osc_stop = cur_w[R_DOW*BYTE_W + RUNSTOP_BIT];
  assign step_en  = tick_i && !load_i && !osc_stop;

  cal_time_chain u_time (
    .step_i    (step_en),
    .hund_i    (cur_w[R_HUND*BYTE_W +: BYTE_W]),
    .sec_i     (cur_w[R_SEC *BYTE_W +: BYTE_W]),
    .min_i     (cur_w[R_MIN *BYTE_W +: BYTE_W]),
    .hour_i    (cur_w[R_HOUR*BYTE_W +: BYTE_W]),
    .hund_o    (nxt_w[R_HUND*BYTE_W +: BYTE_W]),
    .sec_o     (nxt_w[R_SEC *BYTE_W +: BYTE_W]),
    .min_o     (nxt_w[R_MIN *BYTE_W +: BYTE_W]),
    .hour_o    (nxt_w[R_HOUR*BYTE_W +: BYTE_W]),
    .day_roll_o(day_roll)
  );

  cal_date_chain u_date (
    .roll_i     (day_roll),
    .dow_i      (cur_w[R_DOW *BYTE_W +: BYTE_W]),
    .date_i     (cur_w[R_DATE*BYTE_W +: BYTE_W]),
    .mon_i      (cur_w[R_MON *BYTE_W +: BYTE_W]),
    .year_i     (cur_w[R_YEAR*BYTE_W +: BYTE_W]),
    .dow_o      (nxt_w[R_DOW *BYTE_W +: BYTE_W]),
    .date_o     (nxt_w[R_DATE*BYTE_W +: BYTE_W]),
    .mon_o      (nxt_w[R_MON *BYTE_W +: BYTE_W]),
    .year_o     (nxt_w[R_YEAR*BYTE_W +: BYTE_W]),
    .year_wrap_o(year_wrap)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [BYTE_W-1:0] KEEP = keep_mask(k);
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)      q <= RESET_VALUE[k*BYTE_W +: BYTE_W] & KEEP;
      else if (load_i) q <= load_data_i[k*BYTE_W +: BYTE_W] & KEEP;
      else             q <= nxt_w[k*BYTE_W +: BYTE_W];
    end
    assign cur_w[k*BYTE_W +: BYTE_W] = q;
  end

  assign time_o = cur_w;
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker
  import cal_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        tick_i,
  input logic        load_i,
  input logic [63:0] load_data_i,
  input logic [63:0] time_o,
  input logic        step_en,
  input logic        day_roll,
  input logic        year_wrap
);
  localparam logic [63:0] KEEP_W = word_keep();

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(time_o));

  assert_hund_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && time_o[7:0] != 8'h99) |=>
      bcd_to_bin(time_o[7:0]) == bcd_to_bin($past(time_o[7:0])) + 7'd1);

  assert_midnight_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll |=> time_o[23:0] == 24'h0);

  assert_dow_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll |=> time_o[34:32] ==
      (($past(time_o[34:32]) == 3'd7) ? 3'd1 : $past(time_o[34:32]) + 3'd1));

  assert_new_century_R8: assert property (@(posedge clk) disable iff (!rst_n)
    year_wrap |=> time_o[63:40] == 24'h00_01_01);

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && time_o[32 + RUNSTOP_BIT]) |=> $stable(time_o));

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> time_o == ($past(load_data_i) & KEEP_W));

  always @(posedge clk) begin
    if (rst_n) begin
      assert_zero_bits_R11: assert ((time_o & ~KEEP_W) == 64'h0);
    end
  end
endmodule

bind bcd_calendar_clock cal_clock_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .load_i     (load_i),
  .load_data_i(load_data_i),
  .time_o     (time_o),
  .step_en    (step_en),
  .day_roll   (day_roll),
  .year_wrap  (year_wrap)
);

// File: tb/sim_bcd_calendar_clock.sv
`timescale 1ns/1ps
module sim_bcd_calendar_clock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        load_i = 1'b0;
  logic [63:0] load_data_i = 64'h0;
  logic [63:0] time_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  string tag = "R12";

  // reference state (plain integers)
  int m_hu, m_se, m_mi, m_hr, m_pm, m_12, m_dw, m_dt, m_mo, m_yr, m_osc;

  always #10 clk = ~clk;

  bcd_calendar_clock u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
    .load_data_i(load_data_i), .time_o(time_o)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [63:0] mk(input int yr, mo, dt, dw, osc, h12, pm, hr, mi, se, hu);
    logic [7:0] hb;
    hb = bcd(hr);
    if (h12 != 0) hb = {1'b1, 1'b0, pm[0], hb[4:0]};
    return {bcd(yr), bcd(mo), bcd(dt), 2'b00, osc[0], 2'b00, dw[2:0],
            hb, bcd(mi), bcd(se), bcd(hu)};
  endfunction

  function automatic int days_in(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_reset();
    m_hu = 0; m_se = 0; m_mi = 0; m_hr = 0; m_pm = 0; m_12 = 0;
    m_dw = 1; m_dt = 1; m_mo = 1; m_yr = 0; m_osc = 0;
  endtask

  task automatic model_next_day();
    m_dw = (m_dw == 7) ? 1 : m_dw + 1;
    m_dt++;
    if (m_dt > days_in(m_mo, m_yr)) begin
      m_dt = 1;
      m_mo++;
      if (m_mo > 12) begin m_mo = 1; m_yr = (m_yr + 1) % 100; end
    end
  endtask

  task automatic model_apply(input bit tk, input bit ld, input logic [63:0] d);
    if (ld) begin
      m_hu  = d[7:4] * 10 + d[3:0];
      m_se  = d[14:12] * 10 + d[11:8];
      m_mi  = d[22:20] * 10 + d[19:16];
      m_12  = d[31];
      m_pm  = m_12 ? d[29] : 0;
      m_hr  = m_12 ? (d[28] * 10 + d[27:24]) : (d[29:28] * 10 + d[27:24]);
      m_dw  = d[34:32];
      m_osc = d[37];
      m_dt  = d[45:44] * 10 + d[43:40];
      m_mo  = d[52] * 10 + d[51:48];
      m_yr  = d[63:60] * 10 + d[59:56];
    end else if (tk && m_osc == 0) begin
      m_hu++;
      if (m_hu < 100) return;
      m_hu = 0; m_se++;
      if (m_se < 60) return;
      m_se = 0; m_mi++;
      if (m_mi < 60) return;
      m_mi = 0;
      if (m_12 != 0) begin
        if (m_hr == 11) begin
          m_hr = 12; m_pm = 1 - m_pm;
          if (m_pm == 0) model_next_day();
        end else if (m_hr == 12) m_hr = 1;
        else m_hr++;
      end else begin
        m_hr++;
        if (m_hr == 24) begin m_hr = 0; model_next_day(); end
      end
    end
  endtask

  task automatic compare();
    logic [63:0] exp;
    exp = mk(m_yr, m_mo, m_dt, m_dw, m_osc, m_12, m_pm, m_hr, m_mi, m_se, m_hu);
    compared++;
    if (time_o !== exp) begin
      mismatched++;
      $display("FAIL %s: time_o=%h expected=%h", tag, time_o, exp);
    end
  endtask

  task automatic cyc(input bit tk, input bit ld, input logic [63:0] d);
    @(negedge clk);
    tick_i = tk; load_i = ld; load_data_i = d;
    @(posedge clk);
    model_apply(tk, ld, d);
    #2 compare();
  endtask

  task automatic preset(input logic [63:0] d);
    cyc(1'b0, 1'b1, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 64'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tag = "R12"; #1 compare();

    tag = "R1";  ticks(150); cyc(1'b0, 1'b0, 64'h0); cyc(1'b0, 1'b0, 64'h0);
    tag = "R2";  preset(mk(10, 6, 15, 3, 0, 0, 0, 0, 59, 59, 97)); ticks(5);
    preset(mk(10, 6, 15, 3, 0, 0, 0, 9, 12, 59, 99)); ticks(2);
    tag = "R3";  preset(mk(10, 3, 5, 2, 0, 0, 0, 23, 59, 59, 98)); ticks(3);
    preset(mk(10, 3, 5, 2, 0, 0, 0, 19, 59, 59, 99)); ticks(1);
    tag = "R4";  preset(mk(10, 3, 5, 2, 0, 1, 0, 11, 59, 59, 99)); ticks(2);
    preset(mk(10, 3, 5, 2, 0, 1, 1, 12, 59, 59, 99)); ticks(2);
    preset(mk(10, 3, 5, 2, 0, 1, 0, 9, 59, 59, 99)); ticks(1);
    tag = "R5";  preset(mk(10, 3, 5, 7, 0, 1, 1, 11, 59, 59, 99)); ticks(2);
    preset(mk(10, 3, 6, 6, 0, 0, 0, 23, 59, 59, 99)); ticks(1);
    tag = "R6";  preset(mk(10, 4, 30, 1, 0, 0, 0, 23, 59, 59, 99)); ticks(1);
    preset(mk(10, 4, 29, 1, 0, 0, 0, 23, 59, 59, 99)); ticks(1);
    preset(mk(10, 1, 31, 1, 0, 0, 0, 23, 59, 59, 99)); ticks(1);
    preset(mk(10, 11, 30, 1, 0, 0, 0, 23, 59, 59, 99)); ticks(1);
    preset(mk(10, 8, 30, 1, 0, 0, 0, 23, 59, 59, 99)); ticks(1);
    tag = "R7";  preset(mk(23, 2, 28, 1, 0, 0, 0, 23, 59, 59, 99)); ticks(1);
    preset(mk(24, 2, 28, 1, 0, 0, 0, 23, 59, 59, 99)); ticks(1);
    preset(mk(24, 2, 29, 1, 0, 0, 0, 23, 59, 59, 99)); ticks(1);
    preset(mk(0, 2, 28, 1, 0, 0, 0, 23, 59, 59, 99)); ticks(1);
    preset(mk(0, 2, 29, 1, 0, 0, 0, 23, 59, 59, 99)); ticks(1);
    tag = "R8";  preset(mk(99, 12, 31, 5, 0, 0, 0, 23, 59, 59, 99)); ticks(2);
    preset(mk(49, 12, 31, 5, 0, 1, 1, 11, 59, 59, 99)); ticks(1);
    tag = "R9";  preset(mk(10, 5, 5, 2, 1, 0, 0, 23, 59, 59, 99)); ticks(6);
    preset(mk(10, 5, 5, 2, 0, 0, 0, 23, 59, 59, 99)); ticks(2);
    tag = "R10"; cyc(1'b1, 1'b1, mk(33, 7, 14, 4, 0, 0, 0, 8, 30, 0, 50)); ticks(1);
    cyc(1'b1, 1'b1, mk(33, 7, 14, 4, 0, 1, 1, 11, 59, 59, 99)); ticks(1);
    tag = "R11"; preset(mk(15, 9, 20, 3, 0, 0, 0, 14, 25, 36, 47) | 64'h00E0_C0D8_4080_8000);
    ticks(3);
    preset(mk(15, 9, 20, 3, 1, 1, 1, 7, 25, 36, 47) | 64'h00E0_C0D8_4080_8000);
    ticks(2);
    finish_run();
  end
endmodule